// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit resolves the operand address for one instruction of an 8-bit accumulator processor that has X and Y index registers. The sequencer pulses `start` with an addressing-mode code, the address of the first operand byte (`pcIn`) and the current X and Y values. The unit then fetches the operand bytes over a byte-wide read bus and, for the pointer-based modes, the two pointer bytes. It then presents the effective address, the program counter advanced past the operand bytes, and a flag saying whether the extra page-crossing cycle is owed.

The arithmetic follows the processor's quirks rather than plain 16-bit addition. Zero-page indexing and zero-page pointers wrap inside page zero. The indirect jump takes its pointer's second byte from the same page as the first. Absolute-indexed and indirect-Y accesses report a carry into the high byte. The operation itself is executed elsewhere.

The read bus is combinational: `busData` must hold the byte at `busAddr` in the same cycle that `busRd` is high.

Top module: `operand_addr_unit`

## Requirements
- R1: Mode code 0 (immediate) makes no bus read. `done` rises in the cycle after `start` is sampled, with `effAddr` equal to the sampled PC and `pcOut` equal to PC+1.
- R2: Mode codes 1, 2 and 3 (zero page, zero page plus X, zero page plus Y) read one byte at PC. The address is {0x00, byte}, {0x00, (byte+X) mod 256} or {0x00, (byte+Y) mod 256}, and `pcOut` is PC+1.
- R3: Mode code 4 (absolute) reads PC and then PC+1, low byte first. `effAddr` is {second, first} and `pcOut` is PC+2.
- R4: Mode codes 5 and 6 (absolute plus X, plus Y) form the absolute base as in R3 and add the index over 16 bits. `pageCross` is 1 exactly when the result's high byte differs from the base's high byte.
- R5: Mode code 7 (indirect jump) fetches pointer P as in R3, then reads P and {P[15:8], (P[7:0]+1) mod 256}. `effAddr` is {second, first} and `pcOut` is PC+2.
- R6: Mode code 8 (relative) reads one offset byte at PC. `pcOut` is PC+1 and `effAddr` is (PC+1 + sign-extended offset) mod 65536.
- R7: Mode code 9 (indexed indirect) reads operand b at PC and forms z = (b+X) mod 256. It reads {0x00, z} and then {0x00, (z+1) mod 256}, and `effAddr` is {second, first}.
- R8: Mode code 10 (indirect indexed) reads operand b at PC, then {0x00, b} and {0x00, (b+1) mod 256}, giving pointer Q. `effAddr` is Q+Y over 16 bits, and `pageCross` follows the rule of R4 against Q.
- R9: `busRd` is high only in fetch cycles, one per byte read, in the order stated above. `done` is high for exactly one cycle, which follows the last fetch. `pageCross` is 0 for every mode other than 5, 6 and 10.
- R10: PC, X, Y and the mode are sampled at `start`. A `start` pulse or a change on those inputs while a computation is in progress does not alter it.
- R11: Mode codes 11 to 15 make no bus read. `done` rises in the cycle after `start`, with `effAddr` 0, `pcOut` equal to PC, and `pageCross` 0.
- R12: While `rstN` is low, `done` and `busRd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an address computation (sampled only when idle) |
| mode | input | 4 | Addressing-mode code |
| pcIn | input | 16 | Address of the first operand byte |
| xIn | input | 8 | X index value |
| yIn | input | 8 | Y index value |
| busAddr | output | 16 | Read address |
| busRd | output | 1 | Read strobe |
| busData | input | 8 | Byte at busAddr, valid in the same cycle |
| effAddr | output | 16 | Effective address, valid while done is high |
| pcOut | output | 16 | PC advanced past the operand bytes |
| pageCross | output | 1 | Extra page-crossing cycle applies |
| done | output | 1 | Result valid, one-cycle pulse |

## Verification
The bench builds the unit with its default byte width of 8, so the address space is 16 bits and the page is 256 bytes. This keeps every wrap point reachable: page zero, the pointer low byte at 0xFF, and the top of memory. The bench sweeps all sixteen mode codes over a spread of PC values and the index values 0x00, 0x01, 0x7F, 0x80 and 0xFF. Against a hashed memory image, this covers both page-crossing and non-crossing sums. Patched memory bytes force the indirect-jump page wrap, pointer wrap in page zero, a carry out of 0xFFFF and backward branches. Every other sweep operation raises `start` and alters the inputs while the computation is in progress.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_IMM = 4'd0;
  localparam logic [MODE_W-1:0] MODE_ZP  = 4'd1;
  localparam logic [MODE_W-1:0] MODE_ZPX = 4'd2;
  localparam logic [MODE_W-1:0] MODE_ZPY = 4'd3;
  localparam logic [MODE_W-1:0] MODE_ABS = 4'd4;
  localparam logic [MODE_W-1:0] MODE_ABX = 4'd5;
  localparam logic [MODE_W-1:0] MODE_ABY = 4'd6;
  localparam logic [MODE_W-1:0] MODE_IND = 4'd7;
  localparam logic [MODE_W-1:0] MODE_REL = 4'd8;
  localparam logic [MODE_W-1:0] MODE_IZX = 4'd9;
  localparam logic [MODE_W-1:0] MODE_IZY = 4'd10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPLO, ST_OPHI, ST_PTRLO, ST_PTRHI, ST_DONE
  } eaState_e;

  typedef enum logic [1:0] {
    SEL_PC, SEL_PTRLO, SEL_PTRHI
  } addrSel_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic     latch;
    logic     capOpLo;
    logic     capOpHi;
    logic     capPtrLo;
    logic     capPtrHi;
    addrSel_e addrSel;
  } eaCtrl_t;

  function automatic logic readsOperand(input logic [MODE_W-1:0] m);
    return (m >= MODE_ZP) && (m <= MODE_IZY);
  endfunction

  function automatic logic twoByteOperand(input logic [MODE_W-1:0] m);
    return (m == MODE_ABS) || (m == MODE_ABX) || (m == MODE_ABY) || (m == MODE_IND);
  endfunction

  function automatic logic viaPointer(input logic [MODE_W-1:0] m);
    return (m == MODE_IND) || (m == MODE_IZX) || (m == MODE_IZY);
  endfunction

  function automatic logic usesY(input logic [MODE_W-1:0] m);
    return (m == MODE_ZPY) || (m == MODE_ABY) || (m == MODE_IZY);
  endfunction

  function automatic logic crossMode(input logic [MODE_W-1:0] m);
    return (m == MODE_ABX) || (m == MODE_ABY) || (m == MODE_IZY);
  endfunction

endpackage

// File: rtl/ea_control.sv
module ea_control
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] modeIn,
  output eaCtrl_t           ctrl,
  output logic [MODE_W-1:0] modeR,
  output logic              busRd,
  output logic              done
);

  eaState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      modeR <= '0;
    end else begin
      state <= nextState;
      if (ctrl.latch) modeR <= modeIn;
    end
  end

  always_comb begin
    nextState    = state;
    ctrl         = '0;
    ctrl.addrSel = SEL_PC;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.latch = 1'b1;
          nextState  = readsOperand(modeIn) ? ST_OPLO : ST_DONE;
        end
      end
      ST_OPLO: begin
        ctrl.capOpLo = 1'b1;
        if (twoByteOperand(modeR))  nextState = ST_OPHI;
        else if (viaPointer(modeR)) nextState = ST_PTRLO;
        else                        nextState = ST_DONE;
      end
      ST_OPHI: begin
        ctrl.capOpHi = 1'b1;
        nextState    = viaPointer(modeR) ? ST_PTRLO : ST_DONE;
      end
      ST_PTRLO: begin
        ctrl.addrSel  = SEL_PTRLO;
        ctrl.capPtrLo = 1'b1;
        nextState     = ST_PTRHI;
      end
      ST_PTRHI: begin
        ctrl.addrSel  = SEL_PTRHI;
        ctrl.capPtrHi = 1'b1;
        nextState     = ST_DONE;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busRd = (state == ST_OPLO) || (state == ST_OPHI) ||
                 (state == ST_PTRLO) || (state == ST_PTRHI);
  assign done  = (state == ST_DONE);

  // R9: at most one capture strobe per cycle
  p_one_capture_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.capOpLo, ctrl.capOpHi, ctrl.capPtrLo, ctrl.capPtrHi}));

  // R10: a computation in progress never drops straight back to idle
  p_busy_no_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> (state != ST_IDLE));

endmodule

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  eaCtrl_t             ctrl,
  input  logic [MODE_W-1:0]   modeR,
  input  logic [2*BYTE_W-1:0] pcIn,
  input  logic [BYTE_W-1:0]   xIn,
  input  logic [BYTE_W-1:0]   yIn,
  input  logic [BYTE_W-1:0]   busData,
  output logic [2*BYTE_W-1:0] busAddr,
  output logic [2*BYTE_W-1:0] effAddr,
  output logic [2*BYTE_W-1:0] pcOut,
  output logic                pageCross
);

  localparam int ADDR_W = 2 * BYTE_W;

  logic [ADDR_W-1:0] pcR;
  logic [BYTE_W-1:0] xR, yR, opLo, opHi, ptLo, ptHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcR  <= '0;
      xR   <= '0;
      yR   <= '0;
      opLo <= '0;
      opHi <= '0;
      ptLo <= '0;
      ptHi <= '0;
    end else begin
      if (ctrl.latch) begin
        pcR <= pcIn;
        xR  <= xIn;
        yR  <= yIn;
      end
      if (ctrl.capOpLo) begin
        opLo <= busData;
        pcR  <= pcR + ADDR_W'(1);
      end
      if (ctrl.capOpHi) begin
        opHi <= busData;
        pcR  <= pcR + ADDR_W'(1);
      end
      if (ctrl.capPtrLo) ptLo <= busData;
      if (ctrl.capPtrHi) ptHi <= busData;
    end
  end

  logic [BYTE_W-1:0] idx, zIdx;
  logic [ADDR_W-1:0] ptrAddr, ptrNext, absBase, ptrWord, baseSum;

  always_comb begin
    idx     = usesY(modeR) ? yR : xR;
    zIdx    = opLo + idx;
    absBase = {opHi, opLo};
    ptrWord = {ptHi, ptLo};
    unique case (modeR)
      MODE_IND: ptrAddr = absBase;
      MODE_IZX: ptrAddr = {{BYTE_W{1'b0}}, zIdx};
      default:  ptrAddr = {{BYTE_W{1'b0}}, opLo};
    endcase
    // second pointer byte stays in the pointer's page
    ptrNext = {ptrAddr[ADDR_W-1:BYTE_W], ptrAddr[BYTE_W-1:0] + BYTE_W'(1)};
    unique case (ctrl.addrSel)
      SEL_PTRLO: busAddr = ptrAddr;
      SEL_PTRHI: busAddr = ptrNext;
      default:   busAddr = pcR;
    endcase
  end

  always_comb begin
    baseSum   = (modeR == MODE_IZY) ? ptrWord : absBase;
    pcOut     = (modeR == MODE_IMM) ? pcR + ADDR_W'(1) : pcR;
    unique case (modeR)
      MODE_IMM:           effAddr = pcR;
      MODE_ZP:            effAddr = {{BYTE_W{1'b0}}, opLo};
      MODE_ZPX, MODE_ZPY: effAddr = {{BYTE_W{1'b0}}, zIdx};
      MODE_ABS:           effAddr = absBase;
      MODE_ABX, MODE_ABY,
      MODE_IZY:           effAddr = baseSum + {{BYTE_W{1'b0}}, idx};
      MODE_IND, MODE_IZX: effAddr = ptrWord;
      MODE_REL:           effAddr = pcR + {{BYTE_W{opLo[BYTE_W-1]}}, opLo};
      default:            effAddr = '0;
    endcase
    pageCross = crossMode(modeR) &&
                (effAddr[ADDR_W-1:BYTE_W] != baseSum[ADDR_W-1:BYTE_W]);
  end

  // R5: the second pointer fetch stays in the page of the first
  p_ptr_same_page_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capPtrHi |-> busAddr[ADDR_W-1:BYTE_W] == $past(busAddr[ADDR_W-1:BYTE_W]));

  // R3: the high operand byte is read from the address after the low one
  p_operand_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capOpHi |-> busAddr == $past(busAddr) + ADDR_W'(1));

endmodule

// File: rtl/operand_addr_unit.sv
module operand_addr_unit
  import ea_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [3:0]          mode,
  input  logic [2*BYTE_W-1:0] pcIn,
  input  logic [BYTE_W-1:0]   xIn,
  input  logic [BYTE_W-1:0]   yIn,
  output logic [2*BYTE_W-1:0] busAddr,
  output logic                busRd,
  input  logic [BYTE_W-1:0]   busData,
  output logic [2*BYTE_W-1:0] effAddr,
  output logic [2*BYTE_W-1:0] pcOut,
  output logic                pageCross,
  output logic                done
);

  localparam int ADDR_W = 2 * BYTE_W;

  eaCtrl_t           ctrl;
  logic [MODE_W-1:0] modeR;

  ea_control uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .modeIn (mode),
    .ctrl   (ctrl),
    .modeR  (modeR),
    .busRd  (busRd),
    .done   (done)
  );

  ea_datapath #(.BYTE_W(BYTE_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .modeR     (modeR),
    .pcIn      (pcIn),
    .xIn       (xIn),
    .yIn       (yIn),
    .busData   (busData),
    .busAddr   (busAddr),
    .effAddr   (effAddr),
    .pcOut     (pcOut),
    .pageCross (pageCross)
  );

  // R9: done is a single-cycle pulse with the bus quiet
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_no_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busRd);

  // R9: only the indexed-with-carry modes may report a page crossing
  p_cross_modes_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && pageCross) |-> crossMode(modeR));

  // R2: zero-page results never leave page zero
  p_zp_page0_r2: assert property (@(posedge clk) disable iff (!rstN)
    (done && (modeR == MODE_ZP || modeR == MODE_ZPX || modeR == MODE_ZPY))
      |-> effAddr[ADDR_W-1:BYTE_W] == '0);

  // R7, R8: zero-page pointer fetches stay in page zero
  p_zp_pointer_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && ctrl.addrSel != SEL_PC && (modeR == MODE_IZX || modeR == MODE_IZY))
      |-> busAddr[ADDR_W-1:BYTE_W] == '0);

endmodule

// File: tb/operand_addr_unit_test.sv
`timescale 1ns/1ps
module operand_addr_unit_test;

  logic        clk = 1'b0;
  logic        rstN, start;
  logic [3:0]  mode;
  logic [15:0] pcIn, busAddr, effAddr, pcOut;
  logic [7:0]  xIn, yIn, busData;
  logic        busRd, pageCross, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [15:0] pA [4];
  logic [7:0]  pD [4];
  bit          pEn [4];

  always #10 clk = ~clk;

  operand_addr_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .pcIn(pcIn),
    .xIn(xIn), .yIn(yIn), .busAddr(busAddr), .busRd(busRd), .busData(busData),
    .effAddr(effAddr), .pcOut(pcOut), .pageCross(pageCross), .done(done)
  );

  function automatic logic [7:0] hashByte(input logic [15:0] a);
    logic [7:0] t;
    t = 8'(a[7:0] * 8'd29);
    return t ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] rd(input logic [15:0] a);
    logic [7:0] v;
    v = hashByte(a);
    for (int i = 0; i < 4; i++) if (pEn[i] && pA[i] == a) v = pD[i];
    return v;
  endfunction

  always_comb begin
    busData = hashByte(busAddr);
    for (int i = 0; i < 4; i++) if (pEn[i] && pA[i] == busAddr) busData = pD[i];
  end

  function automatic string reqName(input logic [3:0] m);
    case (m)
      4'd0:             return "R1";
      4'd1, 4'd2, 4'd3: return "R2";
      4'd4:             return "R3";
      4'd5, 4'd6:       return "R4";
      4'd7:             return "R5";
      4'd8:             return "R6";
      4'd9:             return "R7";
      4'd10:            return "R8";
      default:          return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clearPatches();
    for (int i = 0; i < 4; i++) pEn[i] = 1'b0;
  endtask

  task automatic setPatch(input int i, input logic [15:0] a, input logic [7:0] d);
    pA[i] = a; pD[i] = d; pEn[i] = 1'b1;
  endtask

  task automatic runOp(input logic [3:0] m, input logic [15:0] pc,
                       input logic [7:0] x, input logic [7:0] y, input bit glitch);
    int n;
    logic [15:0] ea [4];
    logic [15:0] expEff, expPc, base, ptr;
    logic [7:0]  b0, b1, idx, z;
    bit          expCross;
    string       tag;
    n = 0; expEff = '0; expPc = pc; expCross = 1'b0;
    for (int i = 0; i < 4; i++) ea[i] = '0;
    b0 = rd(pc);
    b1 = rd(16'(pc + 16'd1));
    idx = (m == 4'd3 || m == 4'd6 || m == 4'd10) ? y : x;
    case (m)
      4'd0: begin expEff = pc; expPc = 16'(pc + 16'd1); end
      4'd1, 4'd2, 4'd3: begin
        n = 1; ea[0] = pc; expPc = 16'(pc + 16'd1);
        expEff = {8'h00, (m == 4'd1) ? b0 : 8'(b0 + idx)};
      end
      4'd4, 4'd5, 4'd6: begin
        n = 2; ea[0] = pc; ea[1] = 16'(pc + 16'd1); expPc = 16'(pc + 16'd2);
        base = {b1, b0};
        expEff = (m == 4'd4) ? base : 16'(base + {8'h00, idx});
        expCross = (m != 4'd4) && (expEff[15:8] != base[15:8]);
      end
      4'd7: begin
        n = 4; ea[0] = pc; ea[1] = 16'(pc + 16'd1); expPc = 16'(pc + 16'd2);
        ptr = {b1, b0};
        ea[2] = ptr; ea[3] = {ptr[15:8], 8'(ptr[7:0] + 8'd1)};
        expEff = {rd(ea[3]), rd(ea[2])};
      end
      4'd8: begin
        n = 1; ea[0] = pc; expPc = 16'(pc + 16'd1);
        expEff = 16'(expPc + {{8{b0[7]}}, b0});
      end
      4'd9, 4'd10: begin
        n = 3; ea[0] = pc; expPc = 16'(pc + 16'd1);
        z = (m == 4'd9) ? 8'(b0 + x) : b0;
        ea[1] = {8'h00, z}; ea[2] = {8'h00, 8'(z + 8'd1)};
        base = {rd(ea[2]), rd(ea[1])};
        expEff = (m == 4'd9) ? base : 16'(base + {8'h00, y});
        expCross = (m == 4'd10) && (expEff[15:8] != base[15:8]);
      end
      default: begin expEff = '0; expPc = pc; end
    endcase
    tag = (glitch && n > 0) ? "R10" : reqName(m);

    @(negedge clk);
    mode = m; pcIn = pc; xIn = x; yIn = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (glitch && n > 0) begin
      // R10: start and new inputs while busy must be ignored
      start = 1'b1; mode = 4'(m + 4'd5); pcIn = pc ^ 16'h5A5A; xIn = ~x; yIn = ~y;
    end
    for (int i = 0; i < n; i++) begin
      check(busRd === 1'b1 && busAddr === ea[i] && done === 1'b0, tag,
            $sformatf("fetch %0d mode %0d address", i, m), {15'd0, busRd, busAddr},
            {16'h0001, ea[i]});
      @(negedge clk);
      start = 1'b0;
    end
    // R9: done follows the last fetch, bus quiet
    check(done === 1'b1 && busRd === 1'b0, "R9", $sformatf("done timing mode %0d", m),
          {30'd0, done, busRd}, 32'h2);
    check(effAddr === expEff, tag, $sformatf("effAddr mode %0d pc %h", m, pc),
          {16'd0, effAddr}, {16'd0, expEff});
    check(pcOut === expPc, tag, $sformatf("pcOut mode %0d", m), {16'd0, pcOut}, {16'd0, expPc});
    check(pageCross === expCross, tag, $sformatf("pageCross mode %0d", m),
          {31'd0, pageCross}, {31'd0, expCross});
    @(negedge clk);
    check(done === 1'b0 && busRd === 1'b0, "R9", "done single cycle",
          {30'd0, done, busRd}, 32'h0);
  endtask

  initial begin
    logic [7:0] xs [5];
    xs[0] = 8'h00; xs[1] = 8'h01; xs[2] = 8'h7F; xs[3] = 8'h80; xs[4] = 8'hFF;
    rstN = 1'b0; start = 1'b0; mode = '0; pcIn = '0; xIn = '0; yIn = '0;
    clearPatches();
    #5;
    // R12: reset state
    check(done === 1'b0 && busRd === 1'b0, "R12", "reset outputs",
          {30'd0, done, busRd}, 32'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int m = 0; m < 16; m++)
      for (int i = 0; i < 64; i++)
        for (int k = 0; k < 5; k++)
          runOp(4'(m), 16'(i * 1031 + m * 97 + k * 3), xs[k], xs[(k + i) % 5], (i % 2) == 1);

    // R5: pointer low byte 0xFF wraps within its page
    setPatch(0, 16'h1234, 8'hFF); setPatch(1, 16'h1235, 8'h30);
    setPatch(2, 16'h30FF, 8'h11); setPatch(3, 16'h3000, 8'h22);
    runOp(4'd7, 16'h1234, 8'h00, 8'h00, 1'b0);
    clearPatches();
    // R7: zero-page pointer at 0xFF wraps to 0x00
    setPatch(0, 16'h0400, 8'hF0); setPatch(1, 16'h00FF, 8'h34); setPatch(2, 16'h0000, 8'h12);
    runOp(4'd9, 16'h0400, 8'h0F, 8'h00, 1'b0);
    clearPatches();
    // R8: Y carries into the high byte
    setPatch(0, 16'h0500, 8'h80); setPatch(1, 16'h0080, 8'hF0); setPatch(2, 16'h0081, 8'h20);
    runOp(4'd10, 16'h0500, 8'h00, 8'h20, 1'b0);
    clearPatches();
    // R4: base 0xFFFF plus X wraps to 0x0000 with a page crossing
    setPatch(0, 16'h0600, 8'hFF); setPatch(1, 16'h0601, 8'hFF);
    runOp(4'd5, 16'h0600, 8'h01, 8'h00, 1'b0);
    clearPatches();
    // R6: forward past 0xFFFF and backward branch
    setPatch(0, 16'hFFFE, 8'h05); setPatch(1, 16'h0010, 8'h80);
    runOp(4'd8, 16'hFFFE, 8'h00, 8'h00, 1'b0);
    runOp(4'd8, 16'h0010, 8'h00, 8'h00, 1'b0);
    clearPatches();
    // R2: zero page plus X wraps inside page zero
    setPatch(0, 16'h0700, 8'hFF);
    runOp(4'd2, 16'h0700, 8'h02, 8'h00, 1'b0);
    clearPatches();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule